// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment at which a selected transition appears on an asynchronous input pin. The pin is brought into the clock domain through a two-stage synchronizer. An optional glitch filter can then clean it: the filter moves to a new level only after four consecutive samples agree on that level. A transition detector then looks for a rising or a falling transition, as chosen by the user. When the chosen transition appears, the value of an external free-running counter is copied into a capture register.

Each capture also sets a sticky flag. An interrupt request follows that flag while interrupts are enabled. A mode input tells the block that the capture register is being used elsewhere as the counter's TOP value. While that input is high, the pin is ignored entirely and neither the register nor the flag can change. The counter itself and any bus access to the register live outside this block.

Top module: `icap_unit`

## Requirements
- R1: With the filter off, a new pin level first sampled at rising clock edge N produces a capture at edge N+2, and `cap_reg` then holds the `count_val` present at edge N+2.
- R2: With the filter on, the same capture happens at edge N+6, four cycles later than the unfiltered path, and stores the `count_val` present at that edge.
- R3: With the filter on, a pin level held for fewer than four consecutive sampling edges causes no capture, while a level held for four or more does.
- R4: `edge_rise`=1 selects rising transitions and `edge_rise`=0 selects falling ones. The transition of the other polarity causes no capture.
- R5: Toggling `edge_rise` while the pin is held steady causes no capture.
- R6: A capture sets `cap_flag`. The flag stays set until it is cleared, and a later capture overwrites `cap_reg` with the newer count.
- R7: A one-cycle `flag_clr` clears `cap_flag` at the next edge. If a capture happens at that same edge, the capture wins and the flag stays 1.
- R8: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R9: While `cap_is_top` is 1, no capture and no flag set occur. Transitions that happen during this mode are not captured after the mode ends.
- R10: After reset, `cap_reg` is 0 and `cap_flag` and `cap_irq` are 0. The synchronizer and filter start at a low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Raw asynchronous capture input |
| count_val | input | CNT_W | Free-running counter value to timestamp |
| filt_en | input | 1 | 1 routes the pin through the glitch filter |
| edge_rise | input | 1 | 1 = rising transition, 0 = falling transition |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| cap_is_top | input | 1 | Capture register serves as TOP; capture disabled |
| cap_reg | output | CNT_W | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear strobe that lands on exactly the edge where a capture takes effect. Reaching it needs the pin transition timed to the synchronizer latency. The bench keeps a cycle counter, drives the count input from that counter, and places the clear on the second edge after it changes the pin. Filter boundaries are reached by pulses of three and four sampled cycles, and the exact latencies are checked because every capture stores a count that is unique to its cycle.

// File: rtl/icap_pkg.sv
// Shared types for the edge timestamp capture unit.
package icap_pkg;
    // Polarity of the transition that triggers a capture.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
// Shift-register synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; output resets low.
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/icap_glitch_filter.sv
// Majority-free glitch filter. The output moves to a level only after LEN
// consecutive input samples carry that level, which adds LEN cycles of latency.
// Assumes LEN >= 3; state resets low.
module icap_glitch_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int HIST = LEN - 1;

    logic [HIST-1:0] hist;
    logic            all_hi;
    logic            all_lo;

    assign all_hi = d & (&hist);
    assign all_lo = ~d & ~(|hist);

    // Keep the most recent HIST samples of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HIST-2:0], d};
    end

    // Change the output only when every stored sample and the current one agree.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (all_hi) q <= 1'b1;
        else if (all_lo) q <= 1'b0;
    end
endmodule

// File: rtl/icap_edge_capture.sv
// Transition detector, capture register and sticky flag.
// Compares the conditioned input with its previous value, so a change of the
// polarity select alone never creates an event. A capture outranks a clear.
module icap_edge_capture
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig,
    input  logic [CNT_W-1:0] count_val,
    input  logic             edge_rise,
    input  logic             blocked,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_reg,
    output logic             cap_flag
);
    logic      prev;
    logic      rose;
    logic      fell;
    logic      hit;
    edge_sel_e pol;

    assign pol  = edge_sel_e'(edge_rise);
    assign rose = sig & ~prev;
    assign fell = ~sig & prev;
    assign hit  = ((pol == EDGE_RISE) ? rose : fell) & ~blocked;

    // Track the previous conditioned level, even while capture is blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    // Latch the counter on a qualifying transition.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_reg <= '0;
        else if (hit) cap_reg <= count_val;
    end

    // Sticky flag: set by a capture, cleared by the strobe, capture first.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (hit)      cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end
endmodule

// File: rtl/icap_unit.sv
// Edge timestamp capture unit: synchronizer, optional glitch filter,
// polarity-selected transition capture, sticky flag and interrupt request.
// Assumes cap_pin is low during reset and filt_en changes only while the pin is idle.
module icap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter bit HAS_FILTER  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] count_val,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             cap_is_top,
    output logic [CNT_W-1:0] cap_reg,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic pin_sync;
    logic pin_cond;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_pin),
        .q     (pin_sync)
    );

    // Choose the filtered or the direct synchronized level.
    generate
        if (HAS_FILTER) begin : g_filt
            logic pin_filt;
            icap_glitch_filter #(.LEN(FILT_LEN)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_sync),
                .q     (pin_filt)
            );
            assign pin_cond = filt_en ? pin_filt : pin_sync;
        end else begin : g_nofilt
            logic unused_en;
            assign unused_en = filt_en;
            assign pin_cond  = pin_sync;
        end
    endgenerate

    icap_edge_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig       (pin_cond),
        .count_val (count_val),
        .edge_rise (edge_rise),
        .blocked   (cap_is_top),
        .flag_clr  (flag_clr),
        .cap_reg   (cap_reg),
        .cap_flag  (cap_flag)
    );

    // Interrupt request follows the flag while enabled.
    assign cap_irq = cap_flag & irq_en;
endmodule

// File: rtl/icap_unit_chk.sv
// Port-level properties of the capture unit, bound to every icap_unit instance.
module icap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             cap_is_top,
    input logic [CNT_W-1:0] cap_reg,
    input logic             cap_flag,
    input logic             cap_irq
);
    // R8: no request without a flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cap_flag);

    // R8: flag and enable together raise the request
    a_r8_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && irq_en) |-> cap_irq);

    // R6: flag holds while no clear is requested
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R6: a new register value always comes with the flag
    a_r6_reg_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_reg) |-> cap_flag);

    // R9: register frozen while it serves as TOP
    a_r9_top_holds_reg: assert property (@(posedge clk) disable iff (!rst_n)
        cap_is_top |=> $stable(cap_reg));

    // R9: flag cannot rise while it serves as TOP
    a_r9_top_no_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !cap_flag) |=> !cap_flag);
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .cap_is_top (cap_is_top),
    .cap_reg    (cap_reg),
    .cap_flag   (cap_flag),
    .cap_irq    (cap_irq)
);

// File: tb/sim_icap_unit.sv
`timescale 1ns/1ps
module sim_icap_unit;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_pin = 1'b0;
    logic [CNT_W-1:0] count_val = '0;
    logic             filt_en = 1'b0;
    logic             edge_rise = 1'b1;
    logic             irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic             cap_is_top = 1'b0;
    logic [CNT_W-1:0] cap_reg;
    logic             cap_flag;
    logic             cap_irq;

    int checks = 0;
    int errors = 0;
    int tick = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    icap_unit #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_val(count_val),
        .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
        .flag_clr(flag_clr), .cap_is_top(cap_is_top),
        .cap_reg(cap_reg), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    // Vector bits: [6] filter on, [5] rising select, [4:1] pulse length, [0] capture expected
    localparam logic [6:0] VEC [0:9] = '{
        {1'b0, 1'b1, 4'd1, 1'b1},
        {1'b0, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b1, 4'd5, 1'b1},
        {1'b0, 1'b0, 4'd3, 1'b1},
        {1'b1, 1'b1, 4'd3, 1'b0},
        {1'b1, 1'b1, 4'd4, 1'b1},
        {1'b1, 1'b0, 4'd4, 1'b1},
        {1'b1, 1'b0, 4'd2, 1'b0},
        {1'b1, 1'b1, 4'd9, 1'b1},
        {1'b1, 1'b0, 4'd6, 1'b1}
    };

    // Advance to the next falling edge and present the cycle number as the count.
    task automatic step();
        @(negedge clk);
        tick++;
        count_val = CNT_W'(tick);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        // R10: reset state
        chk(cap_reg == 0, "R10 cap_reg", cap_reg, 0);
        chk(cap_flag == 0, "R10 cap_flag", cap_flag, 0);
        chk(cap_irq == 0, "R10 cap_irq", cap_irq, 0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        repeat (4) step();

        // Table walk: R1 R2 R3 R4 latency, filtering and polarity
        for (int i = 0; i < 10; i++) begin
            logic [6:0] v;
            int t0;
            int exp_cap;
            v = VEC[i];
            filt_en = v[6];
            edge_rise = v[5];
            repeat (12) step();
            clear_flag();
            chk(cap_flag == 0, "R7 pre-clear", cap_flag, 0);
            step();
            t0 = tick;
            cap_pin = 1'b1;
            repeat (int'(v[4:1])) step();
            cap_pin = 1'b0;
            repeat (14) step();
            exp_cap = (v[5] ? t0 : t0 + int'(v[4:1])) + (v[6] ? 6 : 2);
            chk(cap_flag == v[0], v[6] ? "R3 filtered flag" : "R4 flag", cap_flag, v[0]);
            chk(cap_irq == v[0], "R8 irq", cap_irq, v[0]);
            if (v[0])
                chk(cap_reg == CNT_W'(exp_cap), v[6] ? "R2 filtered latency" : "R1 direct latency",
                    cap_reg, exp_cap);
        end

        // R8: enable gates the request
        irq_en = 1'b0;
        step();
        chk(cap_irq == 0, "R8 irq masked", cap_irq, 0);
        irq_en = 1'b1;
        step();
        chk(cap_irq == 1, "R8 irq unmasked", cap_irq, 1);

        // R6: second capture while flag set overwrites the register
        begin
            int t0;
            filt_en = 1'b0;
            edge_rise = 1'b1;
            repeat (8) step();
            t0 = tick;
            cap_pin = 1'b1;
            repeat (6) step();
            chk(cap_flag == 1, "R6 flag stays set", cap_flag, 1);
            chk(cap_reg == CNT_W'(t0 + 2), "R6 newer count", cap_reg, t0 + 2);
        end

        // R5: polarity toggles with steady high pin
        clear_flag();
        edge_rise = 1'b0;
        repeat (3) step();
        edge_rise = 1'b1;
        repeat (3) step();
        edge_rise = 1'b0;
        repeat (3) step();
        chk(cap_flag == 0, "R5 no capture on select change", cap_flag, 0);
        cap_pin = 1'b0;
        repeat (6) step();
        edge_rise = 1'b1;

        // R7: clear coinciding with a capture loses
        begin
            int t0;
            chk(cap_flag == 1, "R7 setup flag", cap_flag, 1);
            step();
            t0 = tick;
            cap_pin = 1'b1;
            step();
            step();
            flag_clr = 1'b1;
            step();
            flag_clr = 1'b0;
            chk(cap_flag == 1, "R7 capture beats clear", cap_flag, 1);
            chk(cap_reg == CNT_W'(t0 + 2), "R7 capture value", cap_reg, t0 + 2);
            clear_flag();
            chk(cap_flag == 0, "R7 plain clear", cap_flag, 0);
        end
        cap_pin = 1'b0;
        repeat (6) step();
        clear_flag();

        // R9: TOP mode disconnects the pin
        begin
            logic [CNT_W-1:0] held;
            held = cap_reg;
            cap_is_top = 1'b1;
            step();
            cap_pin = 1'b1;
            repeat (3) step();
            cap_pin = 1'b0;
            step();
            cap_pin = 1'b1;
            repeat (8) step();
            chk(cap_flag == 0, "R9 no flag in TOP mode", cap_flag, 0);
            chk(cap_reg == held, "R9 register held", cap_reg, held);
            cap_is_top = 1'b0;
            repeat (8) step();
            chk(cap_flag == 0, "R9 no late capture", cap_flag, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule